// File: doc/BRIEF.md
# Two-Step Serial Register Programming Port

This block lets a host microprocessor load a small bank of control registers over three wires: a serial clock, a serial data line and an enable line. All three are asynchronous to the chip and are resynchronised into the system clock domain, where their edges are detected. On every rising edge of the serial clock one data bit enters a 16-bit shift register, most significant bit first. Each falling edge of the enable line commits the shift register. The shift register is then cleared.

A register write takes two enable frames. The first frame carries an 8-bit register address, which is held in an address latch. The second frame carries the payload of up to 16 bits. The payload goes into the bank register named by the held address. A payload shorter than 16 bits arrives right-aligned, with its upper bits at zero. Each committed write produces a one-cycle strobe together with the target address and the payload. A payload aimed at an address outside the bank is dropped and produces a one-cycle error pulse instead.

The controller has four states. In `ST_ADDR` it waits for an address frame. An enable fall takes it to `ST_DATA` and latches the address. In `ST_DATA` an enable fall latches the payload. It then moves to `ST_COMMIT` if the address is inside the bank, or to `ST_REJECT` if it is not. `ST_COMMIT` pulses the strobe and writes the bank. `ST_REJECT` pulses the error. Both return to `ST_ADDR` on the next cycle.

Top module: `sreg_prog_port`

## Requirements
- R1: After reset every bank register reads zero, the strobe and the error output are low, and the controller expects an address frame.
- R2: The data line is sampled only at rising edges of the serial clock. A change of the data line while the serial clock is high or low has no effect. Bits are shifted in MSB first.
- R3: The first enable fall after reset, or after a completed write, latches the low 8 bits of the shift register as the address. It writes no register and produces no strobe.
- R4: The next enable fall writes the 16-bit shift register contents into bank register `address`. The bank register's value is visible on `regs_o` bits `[16*address +: 16]` one cycle after the strobe.
- R5: A payload frame of fewer than 16 bits is stored right-aligned, with its upper bits zero.
- R6: The shift register is cleared at every enable fall, so bits from the address frame never appear in the payload.
- R7: Enable falls alternate strictly between the address step and the data step. A rejected write also returns the port to the address step.
- R8: A payload aimed at an address of 8 or more raises `addr_err_o` for exactly one cycle. It raises no strobe and changes no register.
- R9: Each successful write raises `wr_stb_o` for exactly one cycle, with `wr_addr_o` and `wr_data_o` holding the target address and the stored payload.
- R10: A payload frame longer than 16 bits keeps only its last 16 bits.
- R11: A write changes only its target register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_dat_i | input | 1 | Serial data from the host |
| ser_en_i | input | 1 | Frame enable; its falling edge commits a frame |
| wr_stb_o | output | 1 | One-cycle pulse per committed register write |
| wr_addr_o | output | 8 | Latched target address |
| wr_data_o | output | 16 | Latched payload |
| addr_err_o | output | 1 | One-cycle pulse when a payload targets an address outside the bank |
| regs_o | output | 128 | Bank contents; register n is at bits [16*n +: 16] |

## Verification
On every cycle, the assertions check the following:
- the strobe and error pulses last one cycle and never coincide;
- a strobe carries an in-range address;
- the addressed register holds the payload one cycle after the strobe;
- the bank never changes without a strobe.

The bench scenarios are needed for what depends on serial framing, because these checks need a model of the shifted bit stream:
- MSB-first sampling at rising edges only;
- right alignment of short payloads and truncation of long ones;
- clearing of address bits between frames;
- alternation of address and data steps after a rejection.

// File: rtl/sreg_prog_pkg.sv
package sreg_prog_pkg;

    typedef enum logic [1:0] {
        ST_ADDR   = 2'd0,
        ST_DATA   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_REJECT = 2'd3
    } prog_state_t;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] pipe_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
            prev_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~pipe_q[STAGES-1] & prev_q;

endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en_i,
    input  logic             bit_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clear_i) begin
            word_q <= '0;
        end else if (shift_en_i) begin
            word_q <= {word_q[WIDTH-2:0], bit_i};
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
    import sreg_prog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NREGS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_fall_i,
    input  logic [DATA_W-1:0] shift_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_stb_o,
    output logic              err_o,
    output logic              clear_o
);

    prog_state_t      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              in_range;

    assign in_range = (int'(addr_q) < NREGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ADDR:   if (en_fall_i) state_d = ST_DATA;
            ST_DATA:   if (en_fall_i) state_d = in_range ? ST_COMMIT : ST_REJECT;
            ST_COMMIT: state_d = ST_ADDR;
            ST_REJECT: state_d = ST_ADDR;
            default:   state_d = ST_ADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (en_fall_i) begin
            if (state_q == ST_ADDR) addr_q <= shift_i[ADDR_W-1:0];
            if (state_q == ST_DATA) data_q <= shift_i;
        end
    end

    always_comb begin
        wr_stb_o = (state_q == ST_COMMIT);
        err_o    = (state_q == ST_REJECT);
        clear_o  = en_fall_i;
    end

    assign addr_o = addr_q;
    assign data_o = data_q;

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NREGS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output logic [NREGS*DATA_W-1:0] regs_o
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en_i && (wr_addr_i == ADDR_W'(g)))
                val_q <= wr_data_i;
        end
        assign regs_o[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/sreg_prog_port.sv
module sreg_prog_port #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int NREGS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk_i,
    input  logic                    ser_dat_i,
    input  logic                    ser_en_i,
    output logic                    wr_stb_o,
    output logic [ADDR_W-1:0]       wr_addr_o,
    output logic [DATA_W-1:0]       wr_data_o,
    output logic                    addr_err_o,
    output logic [NREGS*DATA_W-1:0] regs_o
);

    localparam int LINES = 3;
    localparam int L_CLK = 0;
    localparam int L_DAT = 1;
    localparam int L_EN  = 2;

    logic [LINES-1:0]  lvl, rise, fall;
    logic [DATA_W-1:0] shift_word;
    logic              clr;

    sreg_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en_i, ser_dat_i, ser_clk_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    sreg_shifter #(.WIDTH(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (rise[L_CLK]),
        .bit_i      (lvl[L_DAT]),
        .clear_i    (clr),
        .word_o     (shift_word)
    );

    sreg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_fall_i (fall[L_EN]),
        .shift_i   (shift_word),
        .addr_o    (wr_addr_o),
        .data_o    (wr_data_o),
        .wr_stb_o  (wr_stb_o),
        .err_o     (addr_err_o),
        .clear_o   (clr)
    );

    sreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_stb_o),
        .wr_addr_i (wr_addr_o),
        .wr_data_i (wr_data_o),
        .regs_o    (regs_o)
    );

endmodule

// File: rtl/sreg_prog_port_chk.sv
module sreg_prog_port_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NREGS  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_stb_o,
    input logic [ADDR_W-1:0]       wr_addr_o,
    input logic [DATA_W-1:0]       wr_data_o,
    input logic                    addr_err_o,
    input logic [NREGS*DATA_W-1:0] regs_o
);

    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sel_word;

    assign idx      = wr_addr_o[IDX_W-1:0];
    assign sel_word = regs_o[idx*DATA_W +: DATA_W];

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R9

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |=> !addr_err_o); // R8

    AST_STB_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb_o && addr_err_o)); // R8

    AST_STB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (int'(wr_addr_o) < NREGS)); // R8

    AST_REG_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> (sel_word == $past(wr_data_o))); // R4

    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_o |=> $stable(regs_o)); // R11

endmodule

bind sreg_prog_port sreg_prog_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb_o   (wr_stb_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .addr_err_o (addr_err_o),
    .regs_o     (regs_o)
);

// File: tb/sreg_prog_port_bench.sv
`timescale 1ns/1ps
module sreg_prog_port_bench;

    localparam int NREGS = 8;
    localparam int HALF  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ser_clk = 1'b0;
    logic              ser_dat = 1'b0;
    logic              ser_en = 1'b0;
    logic              wr_stb;
    logic [7:0]        wr_addr;
    logic [15:0]       wr_data;
    logic              addr_err;
    logic [NREGS*16-1:0] regs;

    always #10 clk = ~clk;

    sreg_prog_port u_sreg_prog_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_dat_i  (ser_dat),
        .ser_en_i   (ser_en),
        .wr_stb_o   (wr_stb),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .addr_err_o (addr_err),
        .regs_o     (regs)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [15:0] d;
    } item_t;

    item_t       exp_q[$];
    logic [15:0] model[NREGS];
    int          checks = 0;
    int          errors = 0;
    int          exp_err = 0;
    int          seen_err = 0;
    bit          done = 1'b0;
    logic        prev_stb = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: pops expected writes as strobes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb && prev_stb) chk(1'b0, "R9 strobe longer than one cycle", 32'd2, 32'd1);
            if (wr_stb) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R8 unexpected strobe", {24'd0, wr_addr}, 32'hFF);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(wr_addr == it.a, "R9 strobe address", {24'd0, wr_addr}, {24'd0, it.a});
                    chk(wr_data == it.d, "R4 strobe payload", {16'd0, wr_data}, {16'd0, it.d});
                end
            end
            if (addr_err) seen_err++;
            prev_stb <= wr_stb;
        end
    end

    task automatic send_frame(input logic [31:0] val, input int nbits);
        @(negedge clk);
        ser_en = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = val[i];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF / 2) @(negedge clk);
            ser_dat = ~ser_dat;     // R2: change while clock high is ignored
            repeat (HALF / 2) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        ser_en = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREGS; i++)
            chk(regs[i*16 +: 16] == model[i], req, {16'd0, regs[i*16 +: 16]}, {16'd0, model[i]});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input int nbits, input string req);
        logic [15:0] e;
        if (nbits >= 16) e = d[15:0];
        else             e = d[15:0] & 16'((32'd1 << nbits) - 1);
        if (int'(a) < NREGS) begin
            item_t it;
            it.a = a;
            it.d = e;
            exp_q.push_back(it);
            model[a[2:0]] = e;
        end else begin
            exp_err++;
        end
        send_frame({24'd0, a}, 8);
        send_frame(d, nbits);
        check_bank(req);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = 16'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(wr_stb == 1'b0, "R1 strobe low", {31'd0, wr_stb}, 32'd0);
        chk(addr_err == 1'b0, "R1 error low", {31'd0, addr_err}, 32'd0);
        check_bank("R1 bank zero");

        do_write(8'h00, 32'hA5C3, 16, "R4 full word R11");       // R2 R4 R11
        do_write(8'h07, 32'h1234, 16, "R4 top address R11");
        do_write(8'h03, 32'h000A, 4,  "R5 R6 short payload");    // address bits must not leak
        do_write(8'h05, 32'h03FF, 10, "R5 ten-bit payload");
        do_write(8'h40, 32'hBEEF, 16, "R8 out of range ignored");
        do_write(8'h08, 32'h5555, 16, "R8 first out-of-range ignored");
        do_write(8'h06, 32'h8001, 16, "R7 alternation after reject");
        do_write(8'h01, 32'h000ABCDE, 20, "R10 long payload truncated");

        // R3: address frame alone writes nothing
        send_frame(32'h02, 8);
        check_bank("R3 address step writes nothing");
        begin
            item_t it;
            it.a = 8'h02;
            it.d = 16'hC0DE;
            exp_q.push_back(it);
            model[2] = 16'hC0DE;
        end
        send_frame(32'hC0DE, 16);
        check_bank("R7 data step follows address step");

        do_write(8'h00, 32'hFFFF, 16, "R11 overwrite");
        do_write(8'h03, 32'h0001, 1,  "R5 single-bit payload");

        chk(seen_err == exp_err, "R8 error pulse count", seen_err, exp_err);
        chk(exp_q.size() == 0, "R9 missing strobes", exp_q.size(), 32'd0);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

endmodule